// File: doc/BRIEF.md
# Prescaled Dual-Channel Pulse Width Modulator

This block produces one pulse-width-modulated output per channel (two channels by default). Each channel divides the input clock by a programmable 6-bit prescaler. The divided tick advances a 10-bit position counter that sweeps from zero up to a programmed top value and then wraps. The output is high while the position is below a programmed duty count. A separate full-on flag holds the output high for the whole period.

Software programs each channel through a small word-addressed register bus. New values go into shadow registers. A running channel picks them up only when a period wraps, so a pulse is never cut short or stretched by a write. Each channel has its own enable input. A per-channel stop-mode bit selects what happens when enable drops: either the current period is allowed to finish, or the output is forced low at once.

Top module: `pwm_pair`

## Requirements
- R1: With divider value S and top value T, one output period lasts exactly (S+1)*(T+1) clock cycles, so a window of K whole periods contains exactly K rising edges whenever the output is not constant.
- R2: With duty count D in the range 1 to T, the output is high for (S+1)*D clock cycles per period, at the start of the period.
- R3: A duty count of 0 keeps the output low for the whole period. A duty count greater than T keeps it high for the whole period.
- R4: Duty register bit 10 (full-on flag), when set, holds the output high for every cycle of the period, even when the duty count is 0.
- R5: Each channel c owns three word registers at base 0x10*c:
  - Offset 0x00 (control): bits [5:0] divider value, bit 6 stop mode.
  - Offset 0x04 (duty): bits [9:0] duty count, bit 10 full-on flag.
  - Offset 0x08 (top): bits [9:0] top value.
  A read returns the stored shadow value with unused bits zero, one cycle after the read strobe. Offset 0x0C and addresses whose two low bits are nonzero read as zero and ignore writes. Read data is zero in cycles without a read strobe.
- R6: A register write made while a channel runs does not change the period in progress. The new values take effect from the next period boundary.
- R7: With stop mode set (control bit 6 = 1), the output is low from the first clock edge at which enable is sampled low, and stays low.
- R8: With stop mode clear, dropping enable lets the current period complete unchanged. After that the output stays low and no new period starts.
- R9: After reset all registers read zero, every channel is idle and every output is low.
- R10: Channels are independent. Writes to one channel do not show in another channel's registers, and an idle channel stays low while another runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_enable | input | NUM_CH (2) | Per-channel run enable |
| pwm_out | output | NUM_CH (2) | Registered PWM outputs |

## Verification
Each kind of internal fault shows at the ports within a short, bounded time:

- A miscounting divider or position counter changes the number of high cycles and rising edges in a window of whole periods. The window is phase-independent, so one or two periods of any setting expose the fault.
- A shadow value loaded too early shows as the wrong length of the very pulse during which the write happened.
- A fault in the disable path shows within one clock edge for the immediate stop mode.
- A faulty drain shows within one period as a truncated final pulse or a new pulse after the drain.
- Register decode faults appear on the read data one cycle after the strobe.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int PS_W     = 6;
  localparam int CNT_W    = 10;
  localparam int DATA_W   = 32;
  localparam int STOP_BIT = PS_W;
  localparam int FULL_BIT = CNT_W;

  typedef enum logic [1:0] {
    SLOT_CTRL   = 2'd0,
    SLOT_DUTY   = 2'd1,
    SLOT_TOP    = 2'd2,
    SLOT_NONE   = 2'd3
  } slot_e;

  typedef struct packed {
    logic             stop_now;
    logic [PS_W-1:0]  div;
    logic             full;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] top;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm_pair_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] limit,
  output logic            tick
);
  logic [PS_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pair_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      stop_now,
  input  chan_cfg_t shadow,
  output logic      wave
);
  logic             running;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] duty_a;
  logic [CNT_W-1:0] top_a;
  logic [PS_W-1:0]  div_a;
  logic             full_a;
  logic             tick;
  logic             at_end;
  logic             kill;
  logic             level;
  logic             load;

  pwm_tick_div u_div (
    .clk   (clk),
    .rst   (rst),
    .run   (running),
    .limit (div_a),
    .tick  (tick)
  );

  assign at_end = tick && (pos == top_a);
  assign kill   = running && !enable && stop_now;
  assign level  = full_a || (pos < duty_a);
  assign load   = enable && (!running || (!kill && at_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pos     <= '0;
      duty_a  <= '0;
      top_a   <= '0;
      div_a   <= '0;
      full_a  <= 1'b0;
      wave    <= 1'b0;
    end else begin
      if (load) begin
        duty_a <= shadow.duty;
        top_a  <= shadow.top;
        div_a  <= shadow.div;
        full_a <= shadow.full;
      end
      if (!running) begin
        running <= enable;
        pos     <= '0;
      end else if (kill) begin
        running <= 1'b0;
        pos     <= '0;
      end else if (at_end) begin
        running <= enable;
        pos     <= '0;
      end else if (tick) begin
        pos <= pos + 1'b1;
      end
      wave <= running && !kill && level;
    end
  end
endmodule

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output chan_cfg_t [NUM_CH-1:0]  cfg
);
  localparam int SEL_W = ADDR_W - 4;

  logic              aligned;
  slot_e             slot;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wbits;

  assign aligned      = (addr[1:0] == 2'b00);
  assign slot         = slot_e'(addr[3:2]);
  assign sel          = addr[ADDR_W-1:4];
  assign unused_wbits = ^wdata[DATA_W-1:FULL_BIT+1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t r;
    logic      hit;
    assign hit    = wr_en && aligned && (sel == SEL_W'(c));
    assign cfg[c] = r;

    always_ff @(posedge clk) begin
      if (rst) begin
        r <= '0;
      end else if (hit) begin
        case (slot)
          SLOT_CTRL: begin
            r.div      <= wdata[PS_W-1:0];
            r.stop_now <= wdata[STOP_BIT];
          end
          SLOT_DUTY: begin
            r.duty <= wdata[CNT_W-1:0];
            r.full <= wdata[FULL_BIT];
          end
          SLOT_TOP:  r.top <= wdata[CNT_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (aligned && (sel == SEL_W'(c))) begin
        case (slot)
          SLOT_CTRL: begin
            rd_word[PS_W-1:0] = cfg[c].div;
            rd_word[STOP_BIT] = cfg[c].stop_now;
          end
          SLOT_DUTY: begin
            rd_word[CNT_W-1:0] = cfg[c].duty;
            rd_word[FULL_BIT]  = cfg[c].full;
          end
          SLOT_TOP:  rd_word[CNT_W-1:0] = cfg[c].top;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_word;
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ch_enable,
  output logic [NUM_CH-1:0] pwm_out
);
  chan_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]      stop_mode;

  pwm_pair_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_wr_en),
    .rd_en (bus_rd_en),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cfg   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign stop_mode[c] = cfg[c].stop_now;

    pwm_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .enable   (ch_enable[c]),
      .stop_now (stop_mode[c]),
      .shadow   (cfg[c]),
      .wave     (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
  import pwm_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
)(
  input logic              clk,
  input logic              rst,
  input logic              bus_rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] stop_mode,
  input logic [NUM_CH-1:0] pwm_out
);
  // R9: the first cycle after reset shows all outputs low
  a_r9_reset_low: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_out == '0));

  // R5: unused bits of each register read as zero
  a_r5_ctrl_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr[3:0] == 4'h0) |=> (bus_rdata[DATA_W-1:STOP_BIT+1] == '0));
  a_r5_duty_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr[3:0] == 4'h4) |=> (bus_rdata[DATA_W-1:FULL_BIT+1] == '0));
  a_r5_top_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr[3:0] == 4'h8) |=> (bus_rdata[DATA_W-1:CNT_W] == '0));
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> (bus_rdata == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R7: immediate stop drives the output low at the next edge
    a_r7_stop_now: assert property (@(posedge clk) disable iff (rst)
      (!ch_enable[c] && stop_mode[c]) |=> !pwm_out[c]);
    // R8: once drained and low, a disabled channel never rises again
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
      (!ch_enable[c] && $past(!ch_enable[c]) && !pwm_out[c]) |=> !pwm_out[c]);
  end
endmodule

bind pwm_pair pwm_pair_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/sim_pwm_pair.sv
`timescale 1ns/1ps
module sim_pwm_pair;
  import pwm_pair_pkg::*;

  localparam int NUM_CH = 2;
  localparam int ADDR_W = 5;
  localparam int K      = 2;
  localparam int NV     = 10;
  // columns: channel, divider, top, duty, full-on
  localparam int V_CH[NV]   = '{0, 1, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_PS[NV]   = '{0, 1, 3, 2, 0, 0, 1, 63, 0, 0};
  localparam int V_PV[NV]   = '{9, 4, 7, 5, 7, 7, 5, 1, 0, 1023};
  localparam int V_DC[NV]   = '{3, 2, 0, 9, 8, 7, 0, 1, 1, 512};
  localparam int V_FULL[NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr_en = 1'b0;
  logic              bus_rd_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_CH-1:0] ch_enable = '0;
  logic [NUM_CH-1:0] pwm_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_pair #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_enable (ch_enable),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_rise(input int ch);
    logic p;
    p = pwm_out[ch];
    @(negedge clk);
    while (!(pwm_out[ch] && !p)) begin
      p = pwm_out[ch];
      @(negedge clk);
    end
  endtask

  task automatic run_len(input int ch, output int len);
    len = 0;
    while (pwm_out[ch]) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    int len;
    int highs;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    chk("R9", "outputs after reset", int'(pwm_out), 0);
    for (int a = 0; a < 32; a += 4) begin
      bus_read(ADDR_W'(a), rd);
      chk("R9", "register after reset", int'(rd), 0);
    end

    // R5: field masks on channel 1, unmapped and misaligned reads
    bus_write(5'h10, 32'hFFFF_FFFF);
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_write(5'h1C, 32'hFFFF_FFFF);
    bus_write(5'h11, 32'h0000_0000);
    bus_read(5'h10, rd);  chk("R5", "ctrl readback", int'(rd), 'h7F);
    bus_read(5'h14, rd);  chk("R5", "duty readback", int'(rd), 'h7FF);
    bus_read(5'h18, rd);  chk("R5", "top readback", int'(rd), 'h3FF);
    bus_read(5'h1C, rd);  chk("R5", "unmapped slot", int'(rd), 0);
    bus_read(5'h15, rd);  chk("R5", "misaligned read", int'(rd), 0);
    // R10: channel 0 untouched by channel 1 writes
    bus_read(5'h00, rd);  chk("R10", "ch0 ctrl isolated", int'(rd), 0);
    bus_read(5'h08, rd);  chk("R10", "ch0 top isolated", int'(rd), 0);

    // Table walk: R1 period, R2 duty, R3 extremes, R4 full-on, R10 isolation
    for (int v = 0; v < NV; v++) begin
      int ch, base, per, hi_exp, hi, rises, other;
      logic prev;
      string req;
      ch   = V_CH[v];
      base = ch * 16;
      per  = (V_PS[v] + 1) * (V_PV[v] + 1);
      if (V_FULL[v] != 0) begin
        hi_exp = K * per;
        req = "R4";
      end else begin
        hi_exp = K * (V_PS[v] + 1) * ((V_DC[v] > V_PV[v]) ? V_PV[v] + 1 : V_DC[v]);
        req = (V_DC[v] == 0 || V_DC[v] > V_PV[v]) ? "R3" : "R2";
      end
      bus_write(ADDR_W'(base),     DATA_W'(64 + V_PS[v]));
      bus_write(ADDR_W'(base + 4), DATA_W'(V_FULL[v] * 1024 + V_DC[v]));
      bus_write(ADDR_W'(base + 8), DATA_W'(V_PV[v]));
      ch_enable[ch] = 1'b1;
      repeat (3) @(negedge clk);
      prev = pwm_out[ch];
      hi = 0; rises = 0; other = 0;
      for (int i = 0; i < K * per; i++) begin
        @(negedge clk);
        if (pwm_out[ch]) hi++;
        if (pwm_out[ch] && !prev) rises++;
        if (pwm_out[1 - ch]) other++;
        prev = pwm_out[ch];
      end
      chk(req, "high cycles in window", hi, hi_exp);
      chk("R1", "rising edges in window", rises, (hi_exp > 0 && hi_exp < K * per) ? K : 0);
      chk("R10", "idle channel stays low", other, 0);
      ch_enable[ch] = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R6: shadow write mid-period takes effect at the next period
    bus_write(5'h00, 32'h0000_0000);
    bus_write(5'h08, 32'd9);
    bus_write(5'h04, 32'd3);
    ch_enable[0] = 1'b1;
    wait_rise(0);
    bus_wr_en = 1'b1; bus_addr = 5'h04; bus_wdata = 32'd7;
    @(negedge clk);
    bus_wr_en = 1'b0;
    len = 1;
    while (pwm_out[0]) begin
      len++;
      @(negedge clk);
    end
    chk("R6", "pulse in progress keeps old duty", len, 3);
    wait_rise(0);
    run_len(0, len);
    chk("R6", "next pulse uses new duty", len, 7);

    // R8: graceful stop finishes the period, then stays low
    wait_rise(0);
    ch_enable[0] = 1'b0;
    run_len(0, len);
    chk("R8", "final pulse completes", len, 7);
    highs = 0;
    repeat (40) begin
      @(negedge clk);
      if (pwm_out[0]) highs++;
    end
    chk("R8", "no pulse after drain", highs, 0);

    // R7: immediate stop cuts the pulse at the next edge
    bus_write(5'h00, 32'h0000_0040);
    ch_enable[0] = 1'b1;
    wait_rise(0);
    ch_enable[0] = 1'b0;
    @(negedge clk);
    chk("R7", "output after immediate stop", int'(pwm_out[0]), 0);
    highs = 0;
    repeat (20) begin
      @(negedge clk);
      if (pwm_out[0]) highs++;
    end
    chk("R7", "stays low after stop", highs, 0);

    report();
    $finish;
  end
endmodule